// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the slave side of a four-wire serial bus in front of a small byte-addressed memory of 512 locations, held in an on-chip register array. The bus pins (chip select, serial clock, serial data in) are brought into the system clock domain through a synchronizer and edge detector. A frame starts on a falling edge of chip select. The first byte is an instruction. Depending on that byte, the frame goes on with an address byte, then data going into the memory or data coming out of it.

Four instructions are served: set the write-enable latch, read the status byte, read the array and write the array. The ninth address bit rides in the instruction byte. A write lands in a small page buffer and is committed to the array only when chip select rises on a whole byte boundary. A committed write holds a busy flag for a fixed number of system clocks, which models the internal programming time. An active-low protect input keeps the write-enable latch cleared.

The serial output comes with a separate drive enable, so a pad can tri-state it. In SPI mode 0, data is sampled on rising serial clock edges and changed after falling ones.

Top module: `spie_top`

## Requirements
- R1: After reset the output enable and busy are low, and the status byte reads 0x00.
- R2: Serial clocks while chip select is high are ignored. After an instruction is complete, further clocks in the same frame are ignored until chip select goes high and then falls again.
- R3: Instruction 0x06 sets the write-enable latch (status bit 1). A write instruction received while the latch is clear is discarded and writes nothing.
- R4: Instructions are decoded with bit 3 masked: 0x03 reads and 0x02 writes, and bit 3 of these two is address bit 8. The status read is exactly 0x05 and set-enable is exactly 0x06. Any other byte is ignored, with no output.
- R5: Instruction 0x05 shifts out the status byte MSB first on clocks 8 to 15. Bit 0 is write-in-progress, bit 1 is the write-enable latch and the other bits are 0. Further bytes repeat a freshly sampled status.
- R6: In an array read, clocks 8 to 15 carry the low address byte MSB first, and data is shifted out MSB first from clock 16.
- R7: A read continues while chip select stays low. The address increments after each byte and wraps from 511 to 0.
- R8: A write stores bytes into a 4-byte page aligned to the address. The offset starts at the address's low two bits and wraps within the page, and locations not written in the frame keep their value.
- R9: A write commits only when chip select rises after at least one full data byte with no partial bits. Otherwise nothing is written and busy stays low.
- R10: A committed write holds busy for exactly WRITE_CYCLES system clocks, then clears the write-enable latch.
- R11: While busy, only the status read is honored. Every other instruction produces no output and no change.
- R12: While the protect input is low, the write-enable latch is cleared and cannot be set.
- R13: The output enable is high only while status or array data is being shifted out, within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for serial data out |
| busy | output | 1 | Write in progress |

## Verification
The bench builds the block with WRITE_CYCLES = 600 and SYNC_STAGES = 2, and runs the serial clock at 16 system clocks per bit. That write time is long enough for a whole status read to fit inside one busy window, so the live write-in-progress bit and the refusal of other instructions during a write can both be observed. It is also short enough that several committed writes fit in one run, and the busy length can be counted to the exact cycle.

// File: rtl/spie_pkg.sv
package spie_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t OP_WREN  = 8'h06;
    localparam byte_t OP_RDSR  = 8'h05;
    localparam byte_t OP_READ  = 8'h03;
    localparam byte_t OP_WRITE = 8'h02;
    localparam int    OP_A8_BIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT,
        ST_SKIP
    } state_t;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       wel;
        logic       wip;
    } status_t;

    function automatic byte_t op_base(input byte_t op);
        return op & ~(byte_t'(1) << OP_A8_BIT);
    endfunction

    function automatic byte_t make_status(input logic wel, input logic wip);
        status_t s;
        s.rsvd = '0;
        s.wel  = wel;
        s.wip  = wip;
        return byte_t'(s);
    endfunction

endpackage

// File: rtl/spie_sync.sv
module spie_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spie_mem.sv
module spie_mem #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 4,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = ADDR_W - OFF_W
) (
    input  logic                        clk,
    input  logic [ADDR_W-1:0]           rd_addr,
    output spie_pkg::byte_t             rd_data,
    input  logic                        commit,
    input  logic [BASE_W-1:0]           commit_base,
    input  logic [PAGE_BYTES-1:0]       commit_mask,
    input  logic [PAGE_BYTES-1:0][7:0]  commit_data
);
    spie_pkg::byte_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (commit_mask[i]) store[{commit_base, OFF_W'(i)}] <= commit_data[i];
            end
        end
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/spie_ctrl.sv
module spie_ctrl
    import spie_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int PAGE_BYTES   = 4,
    parameter int WRITE_CYCLES = 5000,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int BASE_W      = ADDR_W - OFF_W,
    localparam int BW          = $clog2(WRITE_CYCLES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_s,
    input  logic                        sck_s,
    input  logic                        si_s,
    input  logic                        wp_s,
    output logic                        so,
    output logic                        so_oe,
    output logic                        busy,
    output logic                        wel,
    output logic [ADDR_W-1:0]           rd_addr,
    input  byte_t                       rd_data,
    output logic                        commit,
    output logic [BASE_W-1:0]           commit_base,
    output logic [PAGE_BYTES-1:0]       commit_mask,
    output logic [PAGE_BYTES-1:0][7:0]  commit_data
);
    state_t             state;
    logic               cs_d, sck_d;
    logic [2:0]         bit_cnt;
    logic [6:0]         in_sr;
    byte_t              out_sr;
    logic               hold;
    logic               a8;
    logic               is_wr;
    logic [ADDR_W-1:0]  addr;
    logic [OFF_W-1:0]   wb_off;
    logic               wb_any;
    logic [BW-1:0]      busy_cnt;

    logic               sck_rise, sck_fall, cs_fall, cs_rise;
    byte_t              byte_in;
    logic [ADDR_W-1:0]  full_addr;
    logic               active, shifting_out;

    always_comb begin
        sck_rise     = sck_s & ~sck_d;
        sck_fall     = ~sck_s & sck_d;
        cs_fall      = cs_d & ~cs_s;
        cs_rise      = ~cs_d & cs_s;
        byte_in      = {in_sr, si_s};
        full_addr    = ADDR_W'({a8, byte_in});
        active       = (state != ST_IDLE) && (state != ST_SKIP);
        shifting_out = (state == ST_STAT) || (state == ST_RDATA);
        rd_addr      = (state == ST_ADDR) ? full_addr : addr;
        busy         = (busy_cnt != '0);
        so_oe        = shifting_out;
        so           = shifting_out & out_sr[7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cs_d        <= 1'b1;
            sck_d       <= 1'b0;
            bit_cnt     <= '0;
            in_sr       <= '0;
            out_sr      <= '0;
            hold        <= 1'b0;
            a8          <= 1'b0;
            is_wr       <= 1'b0;
            addr        <= '0;
            wb_off      <= '0;
            wb_any      <= 1'b0;
            busy_cnt    <= '0;
            wel         <= 1'b0;
            commit      <= 1'b0;
            commit_base <= '0;
            commit_mask <= '0;
            commit_data <= '0;
        end else begin
            cs_d   <= cs_s;
            sck_d  <= sck_s;
            commit <= 1'b0;

            if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == BW'(1)) wel <= 1'b0;
            end

            if (cs_s) begin
                state <= ST_IDLE;
                if (cs_rise && state == ST_WDATA && bit_cnt == '0 && wb_any) begin
                    commit   <= 1'b1;
                    busy_cnt <= BW'(WRITE_CYCLES);
                end
            end else if (cs_fall) begin
                state   <= ST_CMD;
                bit_cnt <= '0;
                hold    <= 1'b0;
            end else if (active && sck_rise) begin
                in_sr   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    unique case (state)
                        ST_CMD: begin
                            if (byte_in == OP_RDSR) begin
                                state  <= ST_STAT;
                                out_sr <= make_status(wel, busy);
                                hold   <= 1'b1;
                            end else if (busy) begin
                                state <= ST_SKIP;
                            end else if (byte_in == OP_WREN) begin
                                if (wp_s) wel <= 1'b1;
                                state <= ST_SKIP;
                            end else if (op_base(byte_in) == OP_READ) begin
                                a8    <= byte_in[OP_A8_BIT];
                                is_wr <= 1'b0;
                                state <= ST_ADDR;
                            end else if (op_base(byte_in) == OP_WRITE && wel) begin
                                a8          <= byte_in[OP_A8_BIT];
                                is_wr       <= 1'b1;
                                wb_any      <= 1'b0;
                                commit_mask <= '0;
                                state       <= ST_ADDR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            if (is_wr) begin
                                state       <= ST_WDATA;
                                commit_base <= full_addr[ADDR_W-1:OFF_W];
                                wb_off      <= full_addr[OFF_W-1:0];
                            end else begin
                                state  <= ST_RDATA;
                                out_sr <= rd_data;
                                hold   <= 1'b1;
                                addr   <= full_addr + 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            commit_data[wb_off] <= byte_in;
                            commit_mask[wb_off] <= 1'b1;
                            wb_off              <= wb_off + 1'b1;
                            wb_any              <= 1'b1;
                        end
                        ST_RDATA: begin
                            out_sr <= rd_data;
                            hold   <= 1'b1;
                            addr   <= addr + 1'b1;
                        end
                        ST_STAT: begin
                            out_sr <= make_status(wel, busy);
                            hold   <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (shifting_out && sck_fall) begin
                if (hold) hold <= 1'b0;
                else      out_sr <= {out_sr[6:0], 1'b0};
            end

            if (!wp_s) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/spie_top.sv
module spie_top #(
    parameter int ADDR_W       = 9,
    parameter int PAGE_BYTES   = 4,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int BASE_W      = ADDR_W - OFF_W
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe,
    output logic busy
);
    logic                       cs_s, sck_s, si_s, wp_s;
    logic                       wel;
    logic [ADDR_W-1:0]          rd_addr;
    spie_pkg::byte_t            rd_data;
    logic                       commit;
    logic [BASE_W-1:0]          commit_base;
    logic [PAGE_BYTES-1:0]      commit_mask;
    logic [PAGE_BYTES-1:0][7:0] commit_data;

    spie_sync #(
        .W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)
    ) u_sync (
        .clk(clk), .rst(rst),
        .d({cs_n, sck, si, wp_n}),
        .q({cs_s, sck_s, si_s, wp_s})
    );

    spie_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s), .wp_s(wp_s),
        .so(so), .so_oe(so_oe), .busy(busy), .wel(wel),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(commit), .commit_base(commit_base),
        .commit_mask(commit_mask), .commit_data(commit_data)
    );

    spie_mem #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_mem (
        .clk(clk),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(commit), .commit_base(commit_base),
        .commit_mask(commit_mask), .commit_data(commit_data)
    );
endmodule

// File: rtl/spie_chk.sv
module spie_chk (
    input logic clk,
    input logic rst,
    input logic cs_s,
    input logic wp_s,
    input logic wel,
    input logic so_oe,
    input logic busy
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!so_oe && !busy)); // R1

    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> !$past(cs_s)); // R13

    AST_WP_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
        !wp_s |=> !wel); // R12

    AST_LATCH_SET_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(wp_s)); // R12

    AST_LATCH_SET_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy)); // R11

    AST_BUSY_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel); // R10

    AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wel); // R3
endmodule

bind spie_top spie_chk u_chk (
    .clk(clk), .rst(rst), .cs_s(cs_s), .wp_s(wp_s),
    .wel(wel), .so_oe(so_oe), .busy(busy)
);

// File: tb/sim_spie_top.sv
module sim_spie_top;
    localparam int CLK_P  = 10;
    localparam int HALF   = 8;
    localparam int WCYC   = 600;
    localparam int WD_LIM = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic so, so_oe, busy;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         bitn = 0;
    logic [7:0] rx = '0;
    int         busy_run = 0;
    int         busy_len = 0;

    always #(CLK_P/2) clk = ~clk;

    spie_top #(.WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .so(so), .so_oe(so_oe), .busy(busy)
    );

    // monitor: collects output bytes and compares with the scoreboard
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            bitn = 0;
        end else if (so_oe) begin
            rx = {rx[6:0], so};
            bitn++;
            if (bitn == 8) begin
                bitn = 0;
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected output byte (R4/R11/R2): got %02h expected none", rx);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    if (rx !== e) begin
                        fails++;
                        $display("FAIL %s: got %02h expected %02h", t, rx, e);
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (busy) busy_run++;
        else if (busy_run > 0) begin
            busy_len = busy_run;
            busy_run = 0;
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic check(input string t, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si <= b[i];
            clocks(HALF);
            sck <= 1'b1;
            clocks(HALF);
            sck <= 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b);
        bits(b, 8);
    endtask

    task automatic cs_lo;
        cs_n <= 1'b0;
        clocks(HALF);
    endtask

    task automatic cs_hi(input string t);
        clocks(HALF);
        cs_n <= 1'b1;
        clocks(2*HALF);
        check({t, " scoreboard drained"}, exp_q.size(), 0);
    endtask

    task automatic wren;
        cs_lo(); xfer(8'h06); cs_hi("R3 wren");
    endtask

    task automatic rdsr(input logic [7:0] e, input string t);
        cs_lo(); xfer(8'h05); push(e, t); xfer(8'h00); cs_hi(t);
    endtask

    task automatic rd(input logic [8:0] a, input int n);
        cs_lo();
        xfer(a[8] ? 8'h0B : 8'h03);
        xfer(a[7:0]);
        for (int i = 0; i < n; i++) xfer(8'h00);
        cs_hi("R6 read");
    endtask

    task automatic wait_idle;
        int guard = 0;
        while (busy && guard < 4*WCYC) begin
            clocks(1);
            guard++;
        end
        clocks(4);
    endtask

    initial begin
        clocks(WD_LIM);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clocks(5);
        rst <= 1'b0;
        clocks(5);

        // R1 reset state
        check("R1 so_oe after reset", so_oe, 0);
        check("R1 busy after reset", busy, 0);
        // R5 status repeats live on consecutive bytes
        cs_lo(); xfer(8'h05);
        push(8'h00, "R1 status after reset"); xfer(8'h00);
        push(8'h00, "R5 status repeat"); xfer(8'h00);
        cs_hi("R5");

        // R2 clocks with CS high ignored
        for (int i = 0; i < 16; i++) begin
            si <= i[0]; clocks(HALF); sck <= 1'b1; clocks(HALF); sck <= 1'b0;
        end
        check("R2 so_oe while cs high", so_oe, 0);
        rdsr(8'h00, "R2 status untouched");
        // R2 extra clocks after a completed instruction are ignored
        cs_lo(); xfer(8'h06); xfer(8'h05); xfer(8'h00); cs_hi("R2 same frame");
        rdsr(8'h02, "R3 latch set");

        // R8/R10 page write at 0x1FC with address bit 8 in opcode
        cs_lo(); xfer(8'h0A); xfer(8'hFC);
        xfer(8'h5A); xfer(8'hA5); xfer(8'h3C); xfer(8'hC3);
        cs_hi("R8 write");
        check("R10 busy after commit", busy, 1);
        rdsr(8'h03, "R11 status during busy");
        wait_idle();
        check("R10 busy length", busy_len, WCYC);
        rdsr(8'h00, "R10 latch cleared after write");

        wren();
        cs_lo(); xfer(8'h02); xfer(8'h00);
        xfer(8'h01); xfer(8'h02); xfer(8'h03); xfer(8'h04);
        cs_hi("R8 write low");
        wait_idle();

        // R6/R7 read with wrap from 511 to 0
        push(8'h3C, "R6 read 0x1FE"); push(8'hC3, "R7 read 0x1FF");
        push(8'h01, "R7 wrap to 0x000");
        rd(9'h1FE, 3);

        // R3 write without latch is discarded
        cs_lo(); xfer(8'h02); xfer(8'h01); xfer(8'hEE); cs_hi("R3 blocked write");
        check("R3 no busy on blocked write", busy, 0);
        push(8'h01, "R3 0x000 kept"); push(8'h02, "R3 0x001 kept");
        rd(9'h000, 2);

        // R9 aborted writes: partial byte, and no data byte
        wren();
        cs_lo(); xfer(8'h02); xfer(8'h02); xfer(8'h77); bits(8'hF0, 4); cs_hi("R9 partial");
        check("R9 no busy on partial byte", busy, 0);
        cs_lo(); xfer(8'h02); xfer(8'h02); cs_hi("R9 no data");
        check("R9 no busy without data", busy, 0);
        rdsr(8'h02, "R9 latch kept");
        push(8'h03, "R9 0x002 unchanged"); rd(9'h002, 1);

        // R8 page wrap inside the 4-byte page
        cs_lo(); xfer(8'h02); xfer(8'h04);
        xfer(8'hAA); xfer(8'hBB); xfer(8'hCC); xfer(8'hDD);
        cs_hi("R8 fill page");
        wait_idle();
        wren();
        cs_lo(); xfer(8'h02); xfer(8'h06);
        xfer(8'h11); xfer(8'h22); xfer(8'h33);
        cs_hi("R8 wrap write");
        // R11 read during busy yields nothing
        cs_lo(); xfer(8'h03); xfer(8'h04); xfer(8'h00); cs_hi("R11 read while busy");
        check("R11 so_oe after busy read", so_oe, 0);
        wait_idle();
        push(8'h33, "R8 0x004 wrapped"); push(8'hBB, "R8 0x005 kept");
        push(8'h11, "R8 0x006"); push(8'h22, "R8 0x007");
        rd(9'h004, 4);

        // R12 write protect
        wp_n <= 1'b0; clocks(4);
        wren();
        rdsr(8'h00, "R12 wren blocked by wp");
        wp_n <= 1'b1; clocks(4);
        wren();
        rdsr(8'h02, "R12 wren with wp high");
        wp_n <= 1'b0; clocks(4);
        rdsr(8'h00, "R12 wp clears latch");
        wp_n <= 1'b1; clocks(4);

        // R4 unknown opcodes produce no output
        cs_lo(); xfer(8'h9F); xfer(8'h00); xfer(8'h00); cs_hi("R4 unknown");
        cs_lo(); xfer(8'h0D); xfer(8'h00); cs_hi("R4 status with bit3");
        check("R4 so_oe idle", so_oe, 0);
        // R13 output enable dropped after frame
        check("R13 so_oe low between frames", so_oe, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule